// File: doc/BRIEF.md
# Occupancy-Ranked Preference-List Matcher

This block is the central matcher of a three-stage switch with `N` input modules and `N` output modules. It keeps one occupancy counter per (input module, output module) pair. Each cycle is one time slot. In every slot, each input module ranks the output modules it holds cells for by descending occupancy. The matcher then walks the input modules one at a time, starting from a rotating start index. For each input module it grants the highest-ranked output module that no earlier-visited input module has already taken.

The grant is registered and presented as a confirmation during the following slot, which is the slot in which the cells move. The confirmation carries the output-module identifier and the number of cells to send. That number is the queue count capped at `N`. In the same clock edge that registers the grant, the counter is reduced by that amount and increased by any arrival. Only matched pairs carry cells, and there is no fallback path.

Top module: `preflist_matcher`

## Requirements
- R1: While reset is held, and at the first edge after its release, every grant-valid bit is 0, every quantity field is 0 and every counter is 0.
- R2: Arrival bit `arr_i[i*N+j]` adds one cell to counter (i,j). At each edge, that counter becomes its old value, plus that bit, minus the quantity granted to input i if input i was granted output j; otherwise the quantity term is 0.
- R3: An input module is granted the output module with the largest counter among those not yet taken in this slot. Among equal counts, the lower output index wins.
- R4: Input modules are visited in increasing index order modulo N, beginning at the start index. An output module taken by an earlier-visited input is skipped by later ones, which fall through to their next-ranked entry; no output module is granted twice in one slot.
- R5: The start index is 0 in the first slot after reset and advances by one, modulo N, every slot, whether or not any grant is made.
- R6: Output modules with a zero counter never appear in a ranking. An input module whose counters for all free output modules are zero gets no grant: its valid bit is 0 and its quantity field is 0.
- R7: The granted quantity equals the smaller of N and the granted counter, so it lies between 1 and N.
- R8: The grant for input i appears on `gnt_vld_o[i]`, `gnt_om_o[i*IW +: IW]` and `gnt_qty_o[i*QW +: QW]` one edge after the slot whose counters it was computed from, with IW = clog2(N) and QW = clog2(N+1). Counter (i,j) is visible on `cnt_o[(i*N+j)*CW +: CW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per time slot |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_i | input | N*N | One bit per (input, output) pair: one cell arrives this slot |
| gnt_vld_o | output | N | Confirmation present for each input module |
| gnt_om_o | output | N*IW | Granted output-module identifier per input module |
| gnt_qty_o | output | N*QW | Number of cells to transfer per input module |
| cnt_o | output | N*N*CW | Current occupancy counter per pair |

## Verification
The embedded properties watch, on every cycle, that no output module is confirmed to two inputs at once and that each quantity stays within 1..N when valid and is 0 otherwise. They also check that the start index steps by exactly one per slot and that no counter ever rises by more than one cell in a slot. Whether the chosen output really is the best-ranked free one, whether the tie rule and visiting order are honoured, and whether counters drop by exactly the confirmed quantity can only be shown by the bench. The bench replays conflicting, tied, empty and saturating scenarios against its own model of the ranking and greedy walk.

// File: rtl/preflist_matcher.sv
module preflist_matcher #(
  parameter int N  = 4,
  parameter int CW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int QW = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N*N-1:0]    arr_i,
  output logic [N-1:0]      gnt_vld_o,
  output logic [N*IW-1:0]   gnt_om_o,
  output logic [N*QW-1:0]   gnt_qty_o,
  output logic [N*N*CW-1:0] cnt_o
);

  logic [CW-1:0] cnt_q [N][N];
  logic [IW-1:0] rr_q;

  logic [N-1:0]  mv;
  logic [IW-1:0] mo [N];
  logic [QW-1:0] mq [N];

  logic [N-1:0]  vld_q;
  logic [IW-1:0] om_q [N];
  logic [QW-1:0] qty_q [N];

  always_comb begin
    logic [N-1:0]  taken;
    logic [CW-1:0] bc;
    int            idx;
    int            bj;
    taken = '0;
    mv    = '0;
    for (int i = 0; i < N; i++) begin
      mo[i] = '0;
      mq[i] = '0;
    end
    for (int k = 0; k < N; k++) begin
      idx = (int'(rr_q) + k) % N;
      bc  = '0;
      bj  = 0;
      for (int j = 0; j < N; j++) begin
        if (!taken[j] && cnt_q[idx][j] > bc) begin
          bc = cnt_q[idx][j];
          bj = j;
        end
      end
      if (bc != '0) begin
        taken[bj] = 1'b1;
        mv[idx]   = 1'b1;
        mo[idx]   = IW'(bj);
        mq[idx]   = (int'(bc) > N) ? QW'(N) : QW'(bc);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q  <= '0;
      vld_q <= '0;
      for (int i = 0; i < N; i++) begin
        om_q[i]  <= '0;
        qty_q[i] <= '0;
        for (int j = 0; j < N; j++) cnt_q[i][j] <= '0;
      end
    end else begin
      rr_q  <= (int'(rr_q) == N - 1) ? '0 : rr_q + 1'b1;
      vld_q <= mv;
      for (int i = 0; i < N; i++) begin
        om_q[i]  <= mo[i];
        qty_q[i] <= mq[i];
        for (int j = 0; j < N; j++)
          cnt_q[i][j] <= cnt_q[i][j] + CW'(arr_i[i*N+j])
                         - ((mv[i] && int'(mo[i]) == j) ? CW'(mq[i]) : CW'(0));
      end
    end
  end

  assign gnt_vld_o = vld_q;

  for (genvar i = 0; i < N; i++) begin : g_out
    assign gnt_om_o[i*IW +: IW]  = om_q[i];
    assign gnt_qty_o[i*QW +: QW] = qty_q[i];
    for (genvar j = 0; j < N; j++) begin : g_cnt
      assign cnt_o[(i*N+j)*CW +: CW] = cnt_q[i][j];

      // R2
      cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ({1'b0, cnt_q[i][j]} <= {1'b0, $past(cnt_q[i][j])} + 1'b1));
    end

    // R7
    qty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q[i] ? (qty_q[i] != '0 && int'(qty_q[i]) <= N) : (qty_q[i] == '0));
  end

  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++)
        if (vld_q[a] && vld_q[b] && om_q[a] == om_q[b]) dup = 1'b1;
  end

  // R4
  unique_om_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup);

  // R5
  rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (int'(rr_q) == (int'($past(rr_q)) + 1) % N));

endmodule

// File: tb/preflist_matcher_bench.sv
module preflist_matcher_bench;
  localparam int N  = 4;
  localparam int CW = 8;
  localparam int IW = 2;
  localparam int QW = 3;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N*N-1:0]    arr_i = '0;
  logic [N-1:0]      gnt_vld_o;
  logic [N*IW-1:0]   gnt_om_o;
  logic [N*QW-1:0]   gnt_qty_o;
  logic [N*N*CW-1:0] cnt_o;

  preflist_matcher #(.N(N), .CW(CW)) u_preflist_matcher (
    .clk(clk), .rst_n(rst_n), .arr_i(arr_i),
    .gnt_vld_o(gnt_vld_o), .gnt_om_o(gnt_om_o),
    .gnt_qty_o(gnt_qty_o), .cnt_o(cnt_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  int mc [N][N];
  int rr_m = 0;
  int ev [N];
  int eo [N];
  int eq [N];

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // greedy first-free-in-ranked-list model (R3, R4, R5, R6, R7)
  task automatic predict();
    bit taken [N];
    for (int j = 0; j < N; j++) taken[j] = 0;
    for (int k = 0; k < N; k++) begin
      int idx = (rr_m + k) % N;
      int bc = 0;
      int bj = 0;
      for (int j = 0; j < N; j++)
        if (!taken[j] && mc[idx][j] > bc) begin bc = mc[idx][j]; bj = j; end
      ev[idx] = (bc > 0) ? 1 : 0;
      eo[idx] = (bc > 0) ? bj : 0;
      eq[idx] = (bc > N) ? N : bc;
      if (bc > 0) taken[bj] = 1;
    end
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < N; i++) begin
      chk({tag, " R6 valid"}, int'(gnt_vld_o[i]), ev[i]);
      if (ev[i] != 0) chk({tag, " R3/R4/R5/R8 om"}, int'(gnt_om_o[i*IW +: IW]), eo[i]);
      chk({tag, " R7 qty"}, int'(gnt_qty_o[i*QW +: QW]), eq[i]);
      for (int j = 0; j < N; j++)
        chk({tag, " R2 count"}, int'(cnt_o[(i*N+j)*CW +: CW]), mc[i][j]);
    end
  endtask

  task automatic step(logic [N*N-1:0] a, string tag);
    predict();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        mc[i][j] = mc[i][j] + int'(a[i*N+j]) - ((ev[i] != 0 && eo[i] == j) ? eq[i] : 0);
    rr_m = (rr_m + 1) % N;
    arr_i = a;
    @(negedge clk);
    check_all(tag);
  endtask

  function automatic logic [N*N-1:0] rnd_arr(int pct);
    logic [N*N-1:0] a = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (($urandom % 100) < pct && mc[i][j] < 200) a[i*N+j] = 1'b1;
    return a;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin
      ev[i] = 0; eo[i] = 0; eq[i] = 0;
      for (int j = 0; j < N; j++) mc[i][j] = 0;
    end
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    step('0, "R1 first slot");
    step('0, "R6 all empty");
    // tie: input 0 gets cells for outputs 1 and 3 together (R3 tie rule)
    step(16'h000A, "R3 tie load");
    step('0, "R3 tie grant");
    // conflict: inputs 0 and 1 both want output 2, input 1 also output 0 (R4)
    step(16'h0054, "R4 conflict load");
    step(16'h0054, "R4 conflict load2");
    step('0, "R4 conflict grant");
    // fill one input heavily so quantities cap at N (R7)
    for (int t = 0; t < 12; t++) step(16'h000F, "R7 cap");
    for (int t = 0; t < 400; t++) step(rnd_arr(80), "rand heavy");
    for (int t = 0; t < 400; t++) step(rnd_arr(12), "rand light");
    for (int t = 0; t < 200; t++) step('0, "R6 drain");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule